// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block resolves a single load against a snapshot of the store queue. Each cycle a load may be presented with its sequence number, byte address and size. The block compares it in parallel against every store entry. It then picks the youngest store that is older than the load and also touches its bytes.

A store that fully covers the load returns its bytes, shifted into place and trimmed to the load size. A store that overlaps only part of the load, and has not yet been written back, makes the load stall and replay. If no store blocks the load, it is sent to the cache. An uncacheable load that is not at the head of commit is turned away.

Alongside the per-load result, the block keeps three pieces of state:
- a stall record holding the oldest replaying load and the store it waits on;
- a blocked-cache record holding the oldest load that found the cache busy;
- a count of cache ports used since the last tick.

Top module: `stlf_unit`

## Requirements
- R1: During and right after reset, `res_valid`, `res_kind`, `res_data`, `stall_flag`, `stall_st_seq`, `stall_ld_seq`, `blk_flag`, `blk_seq` and `port_cnt` are all zero.
- R2: A load presented with `ld_req` high at a clock edge yields `res_valid` high for exactly the following cycle. With `ld_req` low, `res_valid` is low in the following cycle.
- R3: A store entry takes part in the search only if three things hold: its valid bit is set, its size is non-zero, and its sequence number is not greater than the load's. Among the entries whose byte range `[addr, addr+size)` intersects the load's range, only the one with the largest sequence number decides the outcome.
- R4: When the deciding store covers the load (load address ≥ store address, and load address + load size ≤ store address + store size), the result has `res_kind` = 1 (forward). `res_data` is then the store data shifted right by 8 × (load address AND (store size − 1)) bits, with every byte at or above the load size set to zero. For every other outcome `res_data` is zero.
- R5: When the deciding store overlaps only part of the load and its `st_done` bit is set, the outcome is `res_kind` = 0 (cache access).
- R6: When the deciding store overlaps only part of the load and its `st_done` bit is clear, the outcome is `res_kind` = 2 (replay) and `stall_flag` becomes 1.
- R7: A replay records the load's and the store's sequence numbers only in two cases: no stall is live, or the load is older than the recorded load. A live stall is `stall_flag` set with `stall_clr` low. Otherwise `stall_clr` clears `stall_flag`.
- R8: A load with `ld_uncache` high and `ld_at_head` low gives `res_kind` = 3 (reject, the fault and reschedule indication) whatever the stores hold. With `ld_at_head` high, an uncacheable load is resolved as any other load.
- R9: Each cache-access outcome adds one to `port_cnt`. `tick_clr` zeroes the count before that cycle's addition.
- R10: A cache-access outcome while `cache_blocked` is high sets `blk_flag` and stores the load's sequence number in `blk_seq`. This does not happen if a live record, `blk_flag` set with `blk_clr` low, already holds an older sequence number. Otherwise `blk_clr` clears `blk_flag`.
- R11: A load that no eligible store overlaps gives `res_kind` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Load presented this cycle |
| ld_seq | input | SEQ_W | Load sequence number (smaller is older) |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SZ_W | Load size in bytes |
| ld_uncache | input | 1 | Load is uncacheable |
| ld_at_head | input | 1 | Load is the oldest load and ready to commit |
| cache_blocked | input | 1 | Cache cannot accept an access this cycle |
| tick_clr | input | 1 | Start of a new port-accounting cycle |
| stall_clr | input | 1 | Drop the stall record |
| blk_clr | input | 1 | Drop the blocked-cache record |
| st_valid | input | DEPTH | Store entry valid bits |
| st_seq | input | DEPTH*SEQ_W | Store sequence numbers, entry i at bits i*SEQ_W |
| st_addr | input | DEPTH*ADDR_W | Store byte addresses |
| st_size | input | DEPTH*SZ_W | Store sizes in bytes, 0 = data not yet known |
| st_data | input | DEPTH*DATA_W | Store data, byte 0 in the low bits |
| st_done | input | DEPTH | Store already written back |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 2 | 0 cache, 1 forward, 2 replay, 3 reject |
| res_data | output | DATA_W | Forwarded bytes |
| stall_flag | output | 1 | A replay stall is pending |
| stall_st_seq | output | SEQ_W | Store the stalled load waits on |
| stall_ld_seq | output | SEQ_W | Oldest stalled load |
| blk_flag | output | 1 | A load saw the cache blocked |
| blk_seq | output | SEQ_W | Oldest load that saw the cache blocked |
| port_cnt | output | PORT_W | Cache accesses since the last tick |

## Verification
Every result and every piece of recorded state goes through exactly one register. A load driven on a falling edge is therefore due on the next rising edge. The bench drives on the falling edge and reads the outputs at the following falling edge, after the one rising edge that captured the load. Control-only cycles (tick, clears) are checked the same way. Each check confirms that the result strobe is low and that the records show the effect of that single edge.

// File: rtl/stlf_unit.sv
module stlf_unit #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  parameter int PORT_W = 4,
  localparam int NB   = DATA_W / 8,
  localparam int BW   = $clog2(NB),
  localparam int SZ_W = BW + 1,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_req,
  input  logic [SEQ_W-1:0]         ld_seq,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [SZ_W-1:0]          ld_size,
  input  logic                     ld_uncache,
  input  logic                     ld_at_head,
  input  logic                     cache_blocked,
  input  logic                     tick_clr,
  input  logic                     stall_clr,
  input  logic                     blk_clr,
  input  logic [DEPTH-1:0]         st_valid,
  input  logic [DEPTH*SEQ_W-1:0]   st_seq,
  input  logic [DEPTH*ADDR_W-1:0]  st_addr,
  input  logic [DEPTH*SZ_W-1:0]    st_size,
  input  logic [DEPTH*DATA_W-1:0]  st_data,
  input  logic [DEPTH-1:0]         st_done,
  output logic                     res_valid,
  output logic [1:0]               res_kind,
  output logic [DATA_W-1:0]        res_data,
  output logic                     stall_flag,
  output logic [SEQ_W-1:0]         stall_st_seq,
  output logic [SEQ_W-1:0]         stall_ld_seq,
  output logic                     blk_flag,
  output logic [SEQ_W-1:0]         blk_seq,
  output logic [PORT_W-1:0]        port_cnt
);
  localparam logic [1:0] K_CACHE = 2'd0;
  localparam logic [1:0] K_FWD   = 2'd1;
  localparam logic [1:0] K_RPL   = 2'd2;
  localparam logic [1:0] K_REJ   = 2'd3;

  logic [SEQ_W-1:0]  e_seq  [DEPTH];
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [SZ_W-1:0]   e_size [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];
  logic [DEPTH-1:0]  e_hit, e_full;

  logic [ADDR_W:0] ld_lo, ld_end;
  assign ld_lo  = {1'b0, ld_addr};
  assign ld_end = ld_lo + (ADDR_W+1)'(ld_size);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ADDR_W:0] s_lo, s_end;
    assign e_seq[i]  = st_seq[i*SEQ_W +: SEQ_W];
    assign e_addr[i] = st_addr[i*ADDR_W +: ADDR_W];
    assign e_size[i] = st_size[i*SZ_W +: SZ_W];
    assign e_data[i] = st_data[i*DATA_W +: DATA_W];
    assign s_lo      = {1'b0, e_addr[i]};
    assign s_end     = s_lo + (ADDR_W+1)'(e_size[i]);
    assign e_hit[i]  = st_valid[i] && (e_size[i] != '0) && (e_seq[i] <= ld_seq) &&
                       (ld_lo < s_end) && (ld_end > s_lo);
    assign e_full[i] = (ld_lo >= s_lo) && (ld_end <= s_end);
  end

  logic          found;
  logic [IW-1:0] sel;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (e_hit[i] && (!found || e_seq[i] > e_seq[sel])) begin
        found = 1'b1;
        sel   = IW'(i);
      end
  end

  logic [1:0] kind;
  always_comb begin
    if (ld_uncache && !ld_at_head) kind = K_REJ;
    else if (found && e_full[sel]) kind = K_FWD;
    else if (found && !st_done[sel]) kind = K_RPL;
    else kind = K_CACHE;
  end

  logic [BW-1:0]     off;
  logic [DATA_W-1:0] ld_mask, fwd_data;
  assign off = ld_addr[BW-1:0] & BW'(e_size[sel] - 1'b1);
  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign ld_mask[b*8 +: 8] = {8{SZ_W'(b) < ld_size}};
  end
  assign fwd_data = (e_data[sel] >> {off, 3'b000}) & ld_mask;

  logic stall_live, blk_live;
  assign stall_live = stall_flag && !stall_clr;
  assign blk_live   = blk_flag && !blk_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_kind     <= K_CACHE;
      res_data     <= '0;
      stall_flag   <= 1'b0;
      stall_st_seq <= '0;
      stall_ld_seq <= '0;
      blk_flag     <= 1'b0;
      blk_seq      <= '0;
      port_cnt     <= '0;
    end else begin
      res_valid <= ld_req;
      if (ld_req) begin
        res_kind <= kind;
        res_data <= (kind == K_FWD) ? fwd_data : '0;
      end
      port_cnt <= (tick_clr ? '0 : port_cnt) +
                  PORT_W'(ld_req && kind == K_CACHE);
      if (ld_req && kind == K_RPL) begin
        stall_flag <= 1'b1;
        if (!stall_live || ld_seq < stall_ld_seq) begin
          stall_st_seq <= e_seq[sel];
          stall_ld_seq <= ld_seq;
        end
      end else if (stall_clr) stall_flag <= 1'b0;
      if (ld_req && kind == K_CACHE && cache_blocked) begin
        if (!(blk_live && blk_seq < ld_seq)) begin
          blk_flag <= 1'b1;
          blk_seq  <= ld_seq;
        end
      end else if (blk_clr) blk_flag <= 1'b0;
    end
  end

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> res_valid);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> !res_valid);
  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_uncache && !ld_at_head) |=> (res_kind == K_REJ && res_data == '0));
  assert_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_flag && $past(stall_flag) && !$past(stall_clr)) |->
      (stall_ld_seq <= $past(stall_ld_seq)));
  assert_ports_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == K_CACHE) |->
      (port_cnt == ($past(tick_clr) ? PORT_W'(1) : PORT_W'($past(port_cnt) + 1'b1))));
  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && kind == K_CACHE && cache_blocked) |=> blk_flag);
endmodule

// File: tb/test_stlf_unit.sv
module test_stlf_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        ld_req = 0, ld_uncache = 0, ld_at_head = 0, cache_blocked = 0;
  logic        tick_clr = 0, stall_clr = 0, blk_clr = 0;
  logic [7:0]  ld_seq = 0;
  logic [11:0] ld_addr = 0;
  logic [3:0]  ld_size = 0;
  logic [7:0]   st_valid, st_done;
  logic [63:0]  st_seq;
  logic [95:0]  st_addr;
  logic [31:0]  st_size;
  logic [511:0] st_data;
  logic        res_valid, stall_flag, blk_flag;
  logic [1:0]  res_kind;
  logic [63:0] res_data;
  logic [7:0]  stall_st_seq, stall_ld_seq, blk_seq;
  logic [3:0]  port_cnt;

  logic        b_val [8], b_done [8];
  logic [7:0]  b_seq [8];
  logic [11:0] b_addr [8];
  logic [3:0]  b_size [8];
  logic [63:0] b_data [8];

  always_comb
    for (int i = 0; i < 8; i++) begin
      st_valid[i]          = b_val[i];
      st_done[i]           = b_done[i];
      st_seq[i*8 +: 8]     = b_seq[i];
      st_addr[i*12 +: 12]  = b_addr[i];
      st_size[i*4 +: 4]    = b_size[i];
      st_data[i*64 +: 64]  = b_data[i];
    end

  stlf_unit i_stlf_unit (.*);

  int tests = 0, fails = 0;
  logic       m_stall = 0, m_blk = 0;
  logic [7:0] m_sst = 0, m_sld = 0, m_bseq = 0;
  logic [3:0] m_port = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void predict(input logic [7:0] lseq, input logic [11:0] la,
      input logic [3:0] lsz, input logic unc, input logic head,
      output logic [1:0] k, output logic [63:0] d, output logic [7:0] sseq);
    int best = -1;
    logic [12:0] lo, le, so, se;
    d = '0; sseq = '0; k = 2'd0;
    if (unc && !head) begin k = 2'd3; return; end
    lo = {1'b0, la}; le = lo + 13'(lsz);
    for (int i = 0; i < 8; i++) begin
      so = {1'b0, b_addr[i]}; se = so + 13'(b_size[i]);
      if (b_val[i] && b_size[i] != 0 && b_seq[i] <= lseq && lo < se && le > so &&
          (best < 0 || b_seq[i] > b_seq[best])) best = i;
    end
    if (best < 0) return;
    sseq = b_seq[best];
    so = {1'b0, b_addr[best]}; se = so + 13'(b_size[best]);
    if (lo >= so && le <= se) begin
      k = 2'd1;
      d = b_data[best] >> (8 * (la & (12'(b_size[best]) - 12'd1)));
      if (lsz < 8) d = d & ((64'd1 << (8 * lsz)) - 64'd1);
    end else k = b_done[best] ? 2'd0 : 2'd2;
  endfunction

  task automatic check_state();
    chk("R7 stall flag", stall_flag, m_stall);
    chk("R7 stall load", stall_ld_seq, m_sld);
    chk("R7 stall store", stall_st_seq, m_sst);
    chk("R10 blocked flag", blk_flag, m_blk);
    chk("R10 blocked seq", blk_seq, m_bseq);
    chk("R9 port count", port_cnt, m_port);
  endtask

  task automatic do_ld(input logic [7:0] s, input logic [11:0] a, input logic [3:0] z,
      input logic unc, input logic head, input logic blk,
      input logic tk, input logic sc, input logic bc);
    logic [1:0] k; logic [63:0] d; logic [7:0] ss; string tag;
    ld_req = 1; ld_seq = s; ld_addr = a; ld_size = z; ld_uncache = unc;
    ld_at_head = head; cache_blocked = blk; tick_clr = tk; stall_clr = sc; blk_clr = bc;
    predict(s, a, z, unc, head, k, d, ss);
    if (k == 2) begin
      if (!(m_stall && !sc) || s < m_sld) begin m_sst = ss; m_sld = s; end
      m_stall = 1;
    end else if (sc) m_stall = 0;
    if (k == 0 && blk) begin
      if (!(m_blk && !bc && m_bseq < s)) begin m_blk = 1; m_bseq = s; end
    end else if (bc) m_blk = 0;
    m_port = (tk ? 4'd0 : m_port) + 4'(k == 0);
    @(negedge clk);
    tag = (k == 1) ? "R4" : (k == 2) ? "R6" : (k == 3) ? "R8" : "R11";
    chk("R2 strobe", res_valid, 1);
    chk({tag, " kind"}, res_kind, k);
    chk("R4 data", res_data, d);
    check_state();
    ld_req = 0; tick_clr = 0; stall_clr = 0; blk_clr = 0; cache_blocked = 0;
  endtask

  task automatic do_ctl(input logic tk, input logic sc, input logic bc);
    tick_clr = tk; stall_clr = sc; blk_clr = bc;
    if (sc) m_stall = 0;
    if (bc) m_blk = 0;
    if (tk) m_port = 0;
    @(negedge clk);
    chk("R2 no strobe", res_valid, 0);
    check_state();
    tick_clr = 0; stall_clr = 0; blk_clr = 0;
  endtask

  task automatic set_st(input int i, input logic v, input logic [7:0] s, input logic [11:0] a,
      input logic [3:0] z, input logic [63:0] dd, input logic dn);
    b_val[i] = v; b_seq[i] = s; b_addr[i] = a; b_size[i] = z; b_data[i] = dd; b_done[i] = dn;
  endtask

  task automatic clr_st();
    for (int i = 0; i < 8; i++) set_st(i, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] sz_tab [5];
    sz_tab = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd8};
    void'($urandom(32'd4242));
    clr_st();
    repeat (3) @(negedge clk);
    chk("R1 strobe", res_valid, 0);
    chk("R1 kind", res_kind, 0);
    chk("R1 data", res_data, 0);
    check_state();
    rst_n = 1;
    @(negedge clk);
    check_state();

    set_st(0, 1, 8'd5, 12'd8, 4'd8, 64'h8877665544332211, 0);
    do_ld(8'd9, 12'd10, 4'd2, 0, 0, 0, 0, 0, 0);
    chk("R4 shifted bytes", res_data, 64'h4433);
    set_st(1, 1, 8'd20, 12'd8, 4'd8, 64'hAAAAAAAAAAAAAAAA, 0);
    set_st(2, 1, 8'd3, 12'd8, 4'd8, 64'hBBBBBBBBBBBBBBBB, 0);
    do_ld(8'd9, 12'd12, 4'd4, 0, 0, 0, 0, 0, 0);
    chk("R3 youngest older store", res_data, 64'h88776655);
    do_ctl(0, 0, 0);

    clr_st();
    set_st(3, 1, 8'd5, 12'd8, 4'd4, 64'h1, 0);
    do_ld(8'd9, 12'd10, 4'd4, 0, 0, 0, 0, 0, 0);
    chk("R6 replay", res_kind, 2);
    do_ld(8'd12, 12'd10, 4'd4, 0, 0, 0, 0, 0, 0);
    chk("R7 keeps older load", stall_ld_seq, 8'd9);
    do_ld(8'd7, 12'd10, 4'd4, 0, 0, 0, 0, 0, 0);
    chk("R7 takes older load", stall_ld_seq, 8'd7);
    do_ctl(0, 1, 0);
    chk("R7 cleared", stall_flag, 0);
    b_done[3] = 1;
    do_ld(8'd9, 12'd10, 4'd4, 0, 0, 0, 0, 0, 0);
    chk("R5 written store goes to cache", res_kind, 0);

    clr_st();
    set_st(4, 1, 8'd5, 12'd16, 4'd8, 64'h0102030405060708, 0);
    do_ld(8'd9, 12'd16, 4'd1, 1, 0, 0, 0, 0, 0);
    chk("R8 reject", res_kind, 3);
    do_ld(8'd9, 12'd16, 4'd1, 1, 1, 0, 0, 0, 0);
    chk("R8 head forwards", res_data, 64'h08);
    set_st(4, 1, 8'd5, 12'd16, 4'd0, 64'h0102030405060708, 0);
    do_ld(8'd9, 12'd16, 4'd1, 0, 0, 0, 0, 0, 0);
    chk("R3 sizeless store skipped", res_kind, 0);

    clr_st();
    do_ctl(1, 0, 0);
    do_ld(8'd30, 12'd0, 4'd4, 0, 0, 1, 0, 0, 0);
    do_ld(8'd40, 12'd0, 4'd4, 0, 0, 1, 0, 0, 0);
    chk("R10 older blocked kept", blk_seq, 8'd30);
    do_ld(8'd20, 12'd0, 4'd4, 0, 0, 1, 0, 0, 0);
    chk("R10 older blocked taken", blk_seq, 8'd20);
    chk("R9 three accesses", port_cnt, 4'd3);
    do_ctl(1, 0, 1);
    chk("R9 tick", port_cnt, 0);
    chk("R10 cleared", blk_flag, 0);

    for (int n = 0; n < 3000; n++) begin
      if (n % 8 == 0)
        for (int i = 0; i < 8; i++) begin
          logic [3:0] z;
          z = sz_tab[$urandom % 5];
          set_st(i, ($urandom % 8) != 0, 8'(10 * ((i * 3) % 8) + 5),
                 12'($urandom % 32) & ~(12'(z) - 12'd1) & 12'h1F, z,
                 {$urandom, $urandom}, $urandom % 2);
        end
      begin
        logic [3:0] lz;
        lz = sz_tab[1 + $urandom % 4];
        do_ld(8'(10 * ($urandom % 9) + 7), 12'($urandom % 32) & ~(12'(lz) - 12'd1), lz,
              ($urandom % 8) == 0, $urandom % 2, ($urandom % 4) == 0,
              ($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
      end
      if (n % 50 == 0) do_ctl($urandom % 2, $urandom % 2, $urandom % 2);
    end
    finish_run();
  end
endmodule